// File: doc/BRIEF.md
# Gated pulse accumulator

This block keeps a 16-bit running count tied to one external input pin. It has two operating styles. In event style it adds one for each chosen transition of the pin. In gated style it measures how long the pin stays at its active level, by adding one on every tick of an internal reference clock (the system clock divided by 64) while the gate is open. The transition that closes the gate raises an edge flag. A second flag records a wrap of the count. Each flag has its own interrupt enable and its own interrupt line, and software clears a flag by writing a one to it.

The block also has a free-running divider. A two-bit selector uses it to drive a counting tick for a neighbouring timer. The four choices are an external prescaler pulse, every system clock, one clock in 256 and one clock in 65536. The pin is asynchronous, so it passes through two synchronizing flops before any edge is detected.

Software reaches the block through a small register bus with three live addresses:

- Address 0 is control. Bit 0 enables, bit 1 selects the style, bit 2 sets polarity, bits 4:3 hold the tick selector, bit 5 enables the edge interrupt and bit 6 enables the wrap interrupt.
- Address 1 holds the flags: bit 0 is the edge flag and bit 1 is the wrap flag.
- Address 2 is the count.

Top module: `pulse_accum`

## Requirements
- R1: After reset every register reads zero, both interrupt lines are low and the free divider starts from zero.
- R2: While the enable bit (control bit 0) is 0, pin activity neither changes the count nor sets the edge flag.
- R3: In event style (control bit 1 = 0) the count grows by one for each falling pin edge when polarity (bit 2) is 0, or each rising edge when it is 1. The change shows on the third rising clock edge after the pin moves.
- R4: In gated style (bit 1 = 1) the count grows by one on each reference tick while the synchronized pin is high (polarity 0) or low (polarity 1). A reference tick is one cycle in 64, when the low six bits of the free divider are all ones.
- R5: The edge flag (address 1 bit 0) sets on each counted edge in event style. In gated style it sets on the trailing edge that closes the gate: falling for polarity 0, rising for polarity 1.
- R6: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. When a set and a clear fall in the same cycle, the set wins.
- R7: The edge interrupt line is high exactly when the edge flag is 1 and control bit 5 is 1.
- R8: An increment that takes the count from 0xFFFF to 0x0000 sets the wrap flag (address 1 bit 1). The wrap interrupt line equals that flag ANDed with control bit 6.
- R9: The timer tick output follows control bits 4:3. The value 00 passes the prescaler input, 01 gives a constant one, 10 fires when the low 8 divider bits are all ones, and 11 fires when all 16 are ones.
- R10: A bus write to address 2 loads the count. If an increment falls in the same cycle, the write wins and the increment is dropped.
- R11: Control reads back its seven written bits with all upper bits zero, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pin_in | input | 1 | Asynchronous accumulator input pin |
| presc_tick | input | 1 | Pulse from the timer prescaler |
| tmr_tick | output | 1 | Selected counting tick for the timer |
| irq_edge | output | 1 | Edge interrupt request |
| irq_ovf | output | 1 | Wrap interrupt request |

## Verification
Two pairs of functions can land in the same cycle.

- A bus load of the count can meet a reference-tick increment. The bench provokes this by rewriting the count on every cycle for longer than one tick period while the gate is open.
- A write-one clear of the edge flag can meet a fresh counted edge. The bench provokes this by issuing clears on every cycle while the pin toggles at a different rate.

A behavioural model in the bench applies write-wins for the count and set-wins for the flag, and it judges the read data and both interrupt lines after every clock.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    parameter int ACC_W = 16;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_FLAG = 2'd1;
    localparam logic [1:0] A_CNT  = 2'd2;

    typedef struct packed {
        logic       ovf_ie;
        logic       edge_ie;
        logic [1:0] clksel;
        logic       pol;
        logic       mode;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t            ctrl;
        logic             eflag;
        logic             oflag;
        logic [ACC_W-1:0] count;
    } state_t;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/pacc_div.sv
module pacc_div #(
    parameter int FREE_W  = 16,
    parameter int REF_LOG = 6,
    parameter int MID_LOG = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       presc_tick,
    input  logic [1:0] clksel,
    output logic       ref_tick,
    output logic       tmr_tick
);
    logic [FREE_W-1:0] free_d, free_q;
    logic              mid_tick, full_tick;

    always_comb begin
        free_d    = free_q + 1'b1;
        ref_tick  = &free_q[REF_LOG-1:0];
        mid_tick  = &free_q[MID_LOG-1:0];
        full_tick = &free_q;
        case (clksel)
            2'b00:   tmr_tick = presc_tick;
            2'b01:   tmr_tick = 1'b1;
            2'b10:   tmr_tick = mid_tick;
            default: tmr_tick = full_tick;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) free_q <= '0;
        else        free_q <= free_d;
    end
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
    import pacc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REF_LOG     = 6,
    parameter int MID_LOG     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [ACC_W-1:0] bus_wdata,
    output logic [ACC_W-1:0] bus_rdata,
    input  logic             pin_in,
    input  logic             presc_tick,
    output logic             tmr_tick,
    output logic             irq_edge,
    output logic             irq_ovf
);
    state_t st_d, st_q;
    logic   level, rise, fall, ref_tick;
    logic   edge_hit, gate_open, inc, cnt_wr;

    pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(pin_in),
        .level(level), .rise(rise), .fall(fall)
    );

    pacc_div #(.FREE_W(ACC_W), .REF_LOG(REF_LOG), .MID_LOG(MID_LOG)) u_div (
        .clk(clk), .rst_n(rst_n), .presc_tick(presc_tick),
        .clksel(st_q.ctrl.clksel), .ref_tick(ref_tick), .tmr_tick(tmr_tick)
    );

    always_comb begin
        st_d      = st_q;
        cnt_wr    = bus_wr && (bus_addr == A_CNT);
        edge_hit  = st_q.ctrl.en && (st_q.ctrl.pol ? rise : fall);
        gate_open = st_q.ctrl.pol ? ~level : level;
        inc       = st_q.ctrl.en &&
                    (st_q.ctrl.mode ? (gate_open && ref_tick) : edge_hit);

        if (bus_wr && bus_addr == A_CTRL)
            st_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        if (bus_wr && bus_addr == A_FLAG) begin
            if (bus_wdata[0]) st_d.eflag = 1'b0;
            if (bus_wdata[1]) st_d.oflag = 1'b0;
        end
        if (edge_hit) st_d.eflag = 1'b1;

        if (cnt_wr) begin
            st_d.count = bus_wdata;
        end else if (inc) begin
            st_d.count = st_q.count + 1'b1;
            if (&st_q.count) st_d.oflag = 1'b1;
        end

        case (bus_addr)
            A_CTRL:  bus_rdata = {{(ACC_W-CTRL_W){1'b0}}, st_q.ctrl};
            A_FLAG:  bus_rdata = {{(ACC_W-2){1'b0}}, st_q.oflag, st_q.eflag};
            A_CNT:   bus_rdata = st_q.count;
            default: bus_rdata = '0;
        endcase
        irq_edge = st_q.eflag && st_q.ctrl.edge_ie;
        irq_ovf  = st_q.oflag && st_q.ctrl.ovf_ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pacc_chk.sv
module pacc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic        en,
    input logic        mode,
    input logic        edge_ie,
    input logic        eflag,
    input logic        oflag,
    input logic [15:0] count,
    input logic        rise,
    input logic        fall,
    input logic        ref_tick,
    input logic        irq_edge
);
    logic cnt_wr;
    assign cnt_wr = bus_wr && (bus_addr == 2'd2);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(count));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (count == $past(count) || count == $past(count) + 16'd1));

    // R4
    gated_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode && !ref_tick && !cnt_wr) |=> $stable(count));

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && bus_wdata[0] && !rise && !fall) |=> !eflag);

    // R7
    irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_edge) |-> (eflag && edge_ie));

    // R8
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == 16'hFFFF && !cnt_wr) |=> (count == 16'hFFFF || oflag));
endmodule

bind pulse_accum pacc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .en(st_q.ctrl.en), .mode(st_q.ctrl.mode),
    .edge_ie(st_q.ctrl.edge_ie), .eflag(st_q.eflag), .oflag(st_q.oflag),
    .count(st_q.count), .rise(rise), .fall(fall), .ref_tick(ref_tick),
    .irq_edge(irq_edge)
);

// File: tb/sim_pulse_accum.sv
`timescale 1ns/1ps
module sim_pulse_accum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        pin_in = 1'b0;
    logic        presc_tick = 1'b0;
    logic        tmr_tick, irq_edge, irq_ovf;

    int    n_cmp = 0, n_bad = 0, wd = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    pulse_accum u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .presc_tick(presc_tick), .tmr_tick(tmr_tick),
        .irq_edge(irq_edge), .irq_ovf(irq_ovf)
    );

    always #10 clk = ~clk;

    // behavioural reference
    int m_cnt, m_free, m_ctrl;
    bit m_ef, m_of, m_p1, m_p2, m_p3;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_free = 0; m_ctrl = 0;
            m_ef = 0; m_of = 0; m_p1 = 0; m_p2 = 0; m_p3 = 0;
        end else begin
            bit en, md, pl, rs, fl, hit, gate, inc;
            int nctrl;
            en = m_ctrl[0]; md = m_ctrl[1]; pl = m_ctrl[2];
            rs = m_p2 && !m_p3;
            fl = !m_p2 && m_p3;
            hit  = en && (pl ? rs : fl);
            gate = pl ? !m_p2 : m_p2;
            inc  = en && (md ? (gate && (m_free % 64 == 63)) : hit);
            nctrl = m_ctrl;
            if (bus_wr && bus_addr == 2'd0) nctrl = bus_wdata & 16'h7F;
            if (bus_wr && bus_addr == 2'd1) begin
                if (bus_wdata[0]) m_ef = 0;
                if (bus_wdata[1]) m_of = 0;
            end
            if (hit) m_ef = 1;
            if (bus_wr && bus_addr == 2'd2) m_cnt = bus_wdata;
            else if (inc) begin
                if (m_cnt == 65535) m_of = 1;
                m_cnt = (m_cnt + 1) % 65536;
            end
            m_ctrl = nctrl;
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = pin_in;
            m_free = (m_free + 1) % 65536;
        end
    end

    function automatic int exp_rd();
        case (bus_addr)
            2'd0: return m_ctrl;
            2'd1: return {m_of, m_ef};
            2'd2: return m_cnt;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_tick();
        case ((m_ctrl >> 3) & 3)
            0: return presc_tick;
            1: return 1'b1;
            2: return (m_free % 256) == 255;
            default: return m_free == 65535;
        endcase
    endfunction

    task automatic cmp(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (rst_n && !done) begin
        cmp(cur_tag, bus_rdata, exp_rd());
        cmp("R7", irq_edge, m_ef && m_ctrl[5]);
        cmp("R8", irq_ovf, m_of && m_ctrl[6]);
        cmp("R9", tmr_tick, exp_tick());
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 190000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", wd, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask
    task automatic idle(int n);
        repeat (n) step();
    endtask
    task automatic wr(logic [1:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask
    task automatic pulses(int n, int hi, int lo);
        for (int i = 0; i < n; i++) begin
            pin_in = 1'b1; idle(hi);
            pin_in = 1'b0; idle(lo);
        end
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset values on every address
        cur_tag = "R1";
        for (int a = 0; a < 4; a++) begin bus_addr = a[1:0]; idle(2); end
        // R2 disabled: pin activity ignored
        cur_tag = "R2"; bus_addr = 2'd2;
        pulses(4, 5, 5);
        bus_addr = 2'd1; idle(4);
        // R11 control readback, unused bits masked
        cur_tag = "R11";
        wr(2'd0, 16'hFF80); bus_addr = 2'd0; idle(2);
        bus_addr = 2'd3; idle(2);
        // R3 event mode, falling edges, with both interrupt enables
        cur_tag = "R3";
        wr(2'd0, 16'h0061); bus_addr = 2'd2;
        pulses(5, 4, 6);
        // R5 flag after counted edge, R6 clear
        cur_tag = "R5"; bus_addr = 2'd1; idle(3);
        cur_tag = "R6"; wr(2'd1, 16'h0002); idle(2); wr(2'd1, 16'h0001); idle(2);
        // R3 rising edges
        cur_tag = "R3";
        wr(2'd0, 16'h0065); bus_addr = 2'd2;
        pulses(4, 3, 7);
        // R4 gated, active high
        cur_tag = "R4";
        wr(2'd1, 16'h0003);
        wr(2'd0, 16'h0063); bus_addr = 2'd2;
        pin_in = 1'b1; idle(300); pin_in = 1'b0; idle(100);
        cur_tag = "R5"; bus_addr = 2'd1; idle(3);
        wr(2'd1, 16'h0001);
        // R4 gated, active low
        cur_tag = "R4";
        wr(2'd0, 16'h0067); bus_addr = 2'd2;
        pin_in = 1'b1; idle(150); pin_in = 1'b0; idle(250); pin_in = 1'b1; idle(10);
        cur_tag = "R5"; bus_addr = 2'd1; idle(3);
        // R8 wrap in event mode
        cur_tag = "R8";
        wr(2'd0, 16'h0061); wr(2'd2, 16'hFFFD); bus_addr = 2'd2;
        pulses(5, 4, 4);
        bus_addr = 2'd1; idle(3);
        wr(2'd1, 16'h0002); idle(3);
        // R10 count load colliding with gated ticks
        cur_tag = "R10";
        wr(2'd0, 16'h0063); pin_in = 1'b1; idle(4);
        for (int i = 0; i < 140; i++) wr(2'd2, 16'h1000 + i[15:0]);
        bus_addr = 2'd2; idle(80); pin_in = 1'b0; idle(10);
        // R6 clear colliding with new edges
        cur_tag = "R6";
        wr(2'd0, 16'h0061);
        for (int i = 0; i < 60; i++) begin
            if (i % 3 == 0) pin_in = ~pin_in;
            wr(2'd1, 16'h0001);
        end
        idle(5);
        // R7 enable bit toggled with flag held
        cur_tag = "R7";
        pulses(1, 4, 4);
        wr(2'd0, 16'h0041); idle(3); wr(2'd0, 16'h0061); idle(3);
        // R9 tick source selection
        cur_tag = "R9";
        wr(2'd0, 16'h0000);
        for (int i = 0; i < 40; i++) begin presc_tick = (i % 3 == 1); step(); end
        presc_tick = 1'b0;
        wr(2'd0, 16'h0008); idle(20);
        wr(2'd0, 16'h0010); idle(600);
        wr(2'd0, 16'h0018); idle(66000);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule